// File: doc/BRIEF.md
# MLT-3 Symbol Serializer

This block is the digital transmit path of a 100 Mb/s copper physical layer. Once per symbol period it takes a 5-bit code group and shifts it out serially at the bit rate, most significant bit first. It turns the NRZ bit stream into NRZI and then into a three-level MLT-3 line code. The block runs on the 125 MHz bit clock `clk`. A one-cycle strobe `sym_en`, made outside by dividing the bit clock by five, marks each symbol boundary.

A captured group passes through two registers. First it waits in a holding register. At the next strobe it moves into a parallel-in serial-out shifter. The serial bit then drives the NRZI register. A registered edge detector on the NRZI level advances a four-state MLT-3 level machine with these states:
- `LV_ZERO_UP`: level 0, next step is +1. This is the reset state.
- `LV_POS`: level +1.
- `LV_ZERO_DN`: level 0, next step is −1.
- `LV_NEG`: level −1.

The only transition is ADVANCE, taken when the NRZI level changed in the previous cycle. It runs `LV_ZERO_UP`→`LV_POS`→`LV_ZERO_DN`→`LV_NEG`→`LV_ZERO_UP`. Without a change the machine holds its state.

The line is driven only when all three conditions hold: output enable is high, high-speed mode is selected, and loopback is off. The internal state keeps running while the line is released.

Top module: `mlt3_tx_serializer`

## Requirements
- R1: When `sym_en` is high at a rising edge, `sym_in` is stored in the holding register. Reset puts the idle code 5'b11111 in the holding register and zero in the shifter.
- R2: At each `sym_en` edge the shifter loads the holding register. A group captured at one strobe is therefore sent during the following symbol period, so exactly five bits go out per captured group.
- R3: Bit 4 of each group is serialized first and bit 0 last. One bit goes out per clock.
- R4: An NRZ 1 toggles the NRZI level and an NRZ 0 leaves it unchanged.
- R5: Each NRZI transition advances the MLT-3 level through 0, +1, 0, −1 in that cyclic order. Without a transition the level is held. The level is coded on `line_lvl` as 2'b00 = 0, 2'b01 = +1 and 2'b11 = −1, and 2'b10 never appears.
- R6: A serial bit that is in the shifter's top stage after edge j is reflected on `line_lvl` after edge j+2.
- R7: While `out_en` is low, `line_drive` is 0 and `line_lvl` is 2'b00, whatever the other controls say.
- R8: While `fast_mode` is low (low-speed mode), `line_drive` is 0 and `line_lvl` is 2'b00.
- R9: While `loopback` is high, `line_drive` is 0 and `line_lvl` is 2'b00.
- R10: Releasing the line has no effect on the serializer, NRZI or MLT-3 state. After re-enable the level is the one a continuously driven stream would show.
- R11: After reset the NRZI level is 0 and the level machine is in `LV_ZERO_UP`, so `line_lvl` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_en | input | 1 | Symbol strobe, one cycle in five |
| sym_in | input | 5 | Code group, bit 4 sent first |
| out_en | input | 1 | Line output enable |
| fast_mode | input | 1 | 1 = 100 Mb/s path selected |
| loopback | input | 1 | 1 = loopback, line released |
| line_lvl | output | 2 | MLT-3 level, signed 2-bit code |
| line_drive | output | 1 | 1 = line driven, 0 = high impedance |

## Verification
The hardest point to reach is R10. It requires showing that the line can be released and re-driven in the middle of a stream without losing MLT-3 phase, and that cannot be seen from the ports while the line is released.

The stimulus sends a stream of code groups with each of the eight combinations of the three line controls applied for one symbol period at a time. Every cycle it compares `line_lvl` with the level computed from the running count of ones. After each released period, the first enabled cycle can only match if the level machine kept advancing in the background.

A full sweep of all 32 code groups also drives the machine through every state and both NRZI polarities.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;
    typedef enum logic [1:0] {
        LV_ZERO_UP = 2'd0,
        LV_POS     = 2'd1,
        LV_ZERO_DN = 2'd2,
        LV_NEG     = 2'd3
    } mlt3_state_t;

    localparam logic [1:0] CODE_ZERO = 2'b00;
    localparam logic [1:0] CODE_POS  = 2'b01;
    localparam logic [1:0] CODE_NEG  = 2'b11;
endpackage

// File: rtl/mlt3_symbol_stage.sv
module mlt3_symbol_stage #(
    parameter int          SYM_W     = 5,
    parameter logic [SYM_W-1:0] IDLE_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_en,
    input  logic [SYM_W-1:0] sym_in,
    output logic [SYM_W-1:0] hold_word,
    output logic             ser_bit
);
    localparam int TOP = SYM_W - 1;

    logic [SYM_W-1:0] hold_q;
    logic [SYM_W-1:0] shift_q;

    // R1: holding register, idle code after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= IDLE_CODE;
        else if (sym_en) hold_q <= sym_in;
    end

    // R2/R3: parallel load on the strobe, MSB-first shift otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      shift_q <= '0;
        else if (sym_en) shift_q <= hold_q;
        else             shift_q <= {shift_q[TOP-1:0], 1'b0};
    end

    assign hold_word = hold_q;
    assign ser_bit   = shift_q[TOP];
endmodule

// File: rtl/mlt3_nrzi_stage.sv
module mlt3_nrzi_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_bit,
    output logic nrzi_lvl,
    output logic nrzi_edge
);
    logic nrzi_q;
    logic nrzi_d1;

    // R4: a one toggles, a zero holds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nrzi_q  <= 1'b0;
            nrzi_d1 <= 1'b0;
        end else begin
            nrzi_q  <= nrzi_q ^ ser_bit;
            nrzi_d1 <= nrzi_q;
        end
    end

    assign nrzi_lvl  = nrzi_q;
    assign nrzi_edge = nrzi_q ^ nrzi_d1;
endmodule

// File: rtl/mlt3_level_fsm.sv
module mlt3_level_fsm
    import mlt3_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    output logic [1:0] level_code
);
    mlt3_state_t state_q;
    mlt3_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (advance) begin
            unique case (state_q)
                LV_ZERO_UP: state_d = LV_POS;
                LV_POS:     state_d = LV_ZERO_DN;
                LV_ZERO_DN: state_d = LV_NEG;
                LV_NEG:     state_d = LV_ZERO_UP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_ZERO_UP;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LV_ZERO_UP: level_code = CODE_ZERO;
            LV_POS:     level_code = CODE_POS;
            LV_ZERO_DN: level_code = CODE_ZERO;
            LV_NEG:     level_code = CODE_NEG;
        endcase
    end
endmodule

// File: rtl/mlt3_tx_serializer.sv
module mlt3_tx_serializer #(
    parameter int SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_en,
    input  logic [SYM_W-1:0] sym_in,
    input  logic             out_en,
    input  logic             fast_mode,
    input  logic             loopback,
    output logic [1:0]       line_lvl,
    output logic             line_drive
);
    logic [SYM_W-1:0] hold_word;
    logic             ser_bit;
    logic             nrzi_lvl;
    logic             nrzi_edge;
    logic [1:0]       raw_level;
    logic             drive_ok;

    mlt3_symbol_stage #(.SYM_W(SYM_W), .IDLE_CODE({SYM_W{1'b1}})) u_sym (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .sym_in(sym_in),
        .hold_word(hold_word), .ser_bit(ser_bit)
    );

    mlt3_nrzi_stage u_nrzi (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit),
        .nrzi_lvl(nrzi_lvl), .nrzi_edge(nrzi_edge)
    );

    mlt3_level_fsm u_lvl (
        .clk(clk), .rst_n(rst_n), .advance(nrzi_edge), .level_code(raw_level)
    );

    // R7/R8/R9: any one control releases the line; state keeps running (R10)
    assign drive_ok   = out_en & fast_mode & ~loopback;
    assign line_drive = drive_ok;
    assign line_lvl   = drive_ok ? raw_level : 2'b00;
endmodule

// File: rtl/mlt3_tx_checker.sv
module mlt3_tx_checker #(
    parameter int SYM_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_en,
    input logic [SYM_W-1:0] sym_in,
    input logic             out_en,
    input logic             fast_mode,
    input logic             loopback,
    input logic [1:0]       line_lvl,
    input logic             line_drive,
    input logic [SYM_W-1:0] hold_word,
    input logic [1:0]       raw_level
);
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sym_en |=> hold_word == $past(sym_in));

    assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!line_drive && line_lvl == 2'b00));

    assert_slow_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_mode |-> (!line_drive && line_lvl == 2'b00));

    assert_loop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |-> (!line_drive && line_lvl == 2'b00));

    assert_legal_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        raw_level != 2'b10);

    assert_no_pos_to_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        raw_level == 2'b01 |=> raw_level != 2'b11);

    assert_no_neg_to_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        raw_level == 2'b11 |=> raw_level != 2'b01);
endmodule

bind mlt3_tx_serializer mlt3_tx_checker #(.SYM_W(SYM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .sym_in(sym_in),
    .out_en(out_en), .fast_mode(fast_mode), .loopback(loopback),
    .line_lvl(line_lvl), .line_drive(line_drive),
    .hold_word(hold_word), .raw_level(raw_level)
);

// File: tb/mlt3_tx_serializer_bench.sv
module mlt3_tx_serializer_bench;
    localparam int NSYM  = 66;
    localparam int NBITS = 5 * (NSYM + 1);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_en = 1'b0;
    logic [4:0] sym_in = 5'b0;
    logic       out_en = 1'b1;
    logic       fast_mode = 1'b1;
    logic       loopback = 1'b0;
    logic [1:0] line_lvl;
    logic       line_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mlt3_tx_serializer u_mlt3_tx_serializer (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .sym_in(sym_in),
        .out_en(out_en), .fast_mode(fast_mode), .loopback(loopback),
        .line_lvl(line_lvl), .line_drive(line_drive)
    );

    function automatic logic [4:0] sym_of(int k);
        if (k < 32)      return 5'(k);
        else if (k < 64) return 5'((k * 7 + 3) % 32);
        else             return 5'b11111;
    endfunction

    function automatic logic [2:0] ctl_of(int k);
        if (k >= 32 && k < 64) return 3'(k % 8);
        else                   return 3'b110;
    endfunction

    // stream bit j: five idle ones, then each symbol MSB first
    function automatic bit stream_bit(int j);
        logic [4:0] s;
        if (j < 5) return 1'b1;
        s = sym_of(j / 5 - 1);
        return s[4 - (j % 5)];
    endfunction

    function automatic logic [1:0] lvl_of(int ones);
        case (ones % 4)
            1:       return 2'b01;
            3:       return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(string req, logic [2:0] got, logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got drive/lvl=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int ones = 0;
        repeat (3) @(negedge clk);
        // R11: reset state with line enabled
        check("R11 reset", {line_drive, line_lvl}, 3'b100);
        rst_n = 1'b1;
        for (int n = 0; n < NBITS + 2; n++) begin
            logic [2:0] c;
            logic       d_exp;
            int         k;
            k         = n / 5;
            c         = ctl_of(k);
            sym_en    = (n % 5 == 0);
            sym_in    = sym_of(k < NSYM ? k : NSYM - 1);
            @(posedge clk);
            @(negedge clk);
            out_en    = c[2];
            fast_mode = c[1];
            loopback  = c[0];
            #0.5;
            if (n >= 2) ones += int'(stream_bit(n - 2));
            d_exp = c[2] & c[1] & ~c[0];
            if (!c[2])
                check("R7 out_en low", {line_drive, line_lvl}, 3'b000);
            else if (!c[1])
                check("R8 low-speed mode", {line_drive, line_lvl}, 3'b000);
            else if (c[0])
                check("R9 loopback", {line_drive, line_lvl}, 3'b000);
            else if (k >= 33 && k < 65 && (n % 5) == 0)
                check("R10 resume after release", {line_drive, line_lvl}, {d_exp, lvl_of(ones)});
            else if (n < 7)
                check("R1 idle code R11", {line_drive, line_lvl}, {d_exp, lvl_of(ones)});
            else
                check("R2 R3 R4 R5 R6 stream", {line_drive, line_lvl}, {d_exp, lvl_of(ones)});
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule